// File: doc/BRIEF.md
# Modified Immediate Expander

This combinational unit turns the 12-bit encoded constant field of a data-processing instruction into a full 32-bit operand and a shifter carry-out. A format select picks one of two encodings. In the wide encoding the field lies in the low twelve bits of the instruction word: an 8-bit value rotated right by an even amount. In the compact encoding the field is collected from three separate slices of the instruction word. It then either repeats its low byte in one of four lane patterns, or rotates a byte that has an implied top bit of one.

The unit sits between instruction decode and the operand mux of an execute stage. The caller supplies the current carry flag, which passes through to the carry-out whenever the encoding does not rotate. A second output gives the gathered 12-bit field zero-extended without expansion. Instructions that take a plain 12-bit constant use that output instead.

Top module: `imm_expander`

## Requirements
- R1: With `fmt_compact`=0 the field is `instr_word[11:0]`, and `imm_value` is `instr_word[7:0]` zero-extended and rotated right by twice `instr_word[11:8]`.
- R2: With `fmt_compact`=0, `carry_out` equals `carry_in` when `instr_word[11:8]` is zero; otherwise it equals bit 31 of `imm_value`.
- R3: With `fmt_compact`=1 the field is `{instr_word[26], instr_word[14:12], instr_word[7:0]}`. No other instruction bit changes any output in that format.
- R4: Compact format with field[11:10]=0 and field[9:8]=0 gives `imm_value` = 0x000000XY, where XY is field[7:0].
- R5: Compact format with field[11:10]=0 gives the following values. Field[9:8]=1 gives 0x00XY00XY. Field[9:8]=2 gives 0xXY00XY00. Field[9:8]=3 gives 0xXYXYXYXY.
- R6: Compact format with field[11:10]=0 gives `carry_out` = `carry_in` for all four patterns.
- R7: Compact format with field[11:10]≠0 gives `imm_value` = the 8-bit value {1, field[6:0]}, zero-extended and rotated right by field[11:7]. `carry_out` equals bit 31 of `imm_value`.
- R8: In the compact rotated case the forced one always lands at bit 8 or above, so `imm_value[31:8]` is never zero.
- R9: `imm_plain` is the gathered 12-bit field of the selected format, zero-extended to 32 bits.
- R10: A replication pattern whose byte is zero is accepted and yields `imm_value` = 0. No error indication exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_word | input | 32 | Instruction word that holds the encoded constant |
| fmt_compact | input | 1 | 0 selects the wide encoding, 1 selects the compact encoding |
| carry_in | input | 1 | Current carry flag, passed through when no rotation occurs |
| imm_value | output | 32 | Expanded 32-bit constant |
| carry_out | output | 1 | Shifter carry-out for the expanded constant |
| imm_plain | output | 32 | Gathered 12-bit field, zero-extended |

## Verification
The bench builds the unit with the default package widths: a 32-bit word, a 12-bit field and byte lanes. With those widths the whole field space is only 4096 codes per format, so every code of both encodings can be run against an independent model. That sweep covers both rotation ends (0 and 30 in the wide format, 8 and 31 in the compact format) and every replication pattern with every byte value. Hand-picked vectors add instruction words whose bits outside the field are set, to show they are ignored in each format.

// File: rtl/imm_expand_pkg.sv
package imm_expand_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned FIELD_W = 12;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned LANES   = WORD_W / BYTE_W;
  localparam int unsigned ROT_W   = $clog2(WORD_W);

  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [FIELD_W-1:0] field_t;
  typedef logic [BYTE_W-1:0]  byte_t;
  typedef logic [LANES-1:0]   lane_mask_t;

  // byte replication patterns, encoded by field[9:8]
  typedef enum logic [1:0] {
    REP_LOW      = 2'd0,
    REP_HALVES   = 2'd1,
    REP_ODD_LANE = 2'd2,
    REP_ALL      = 2'd3
  } rep_pat_e;

  // rotate a word right; an amount of zero returns the word unchanged
  function automatic word_t rotr_word(word_t v, logic [ROT_W-1:0] amt);
    return (v >> amt) | (v << (WORD_W - amt));
  endfunction

  // which byte lanes carry the replicated byte
  function automatic lane_mask_t lane_mask(rep_pat_e p);
    lane_mask_t m;
    case (p)
      REP_LOW:      m = 4'b0001;
      REP_HALVES:   m = 4'b0101;
      REP_ODD_LANE: m = 4'b1010;
      default:      m = 4'b1111;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/imm_field_gather.sv
module imm_field_gather
  import imm_expand_pkg::*;
#(
  parameter int unsigned TOP_BIT = 26,
  parameter int unsigned MID_HI  = 14,
  parameter int unsigned MID_LO  = 12
) (
  input  word_t  instr_word,
  input  logic   fmt_compact,
  output field_t field
);

  field_t wide_field;
  field_t compact_field;
  logic   unused_instr_bits;

  assign wide_field    = instr_word[FIELD_W-1:0];
  assign compact_field = {instr_word[TOP_BIT], instr_word[MID_HI:MID_LO],
                          instr_word[BYTE_W-1:0]};
  assign field         = fmt_compact ? compact_field : wide_field;

  assign unused_instr_bits = ^{instr_word[WORD_W-1:TOP_BIT+1],
                               instr_word[TOP_BIT-1:MID_HI+1]};

endmodule

// File: rtl/imm_wide_expand.sv
module imm_wide_expand
  import imm_expand_pkg::*;
(
  input  field_t field,
  input  logic   carry_in,
  output word_t  value,
  output logic   carry_out,
  output logic   rot_happened
);

  logic [ROT_W-1:0] rot_amt;
  word_t            base;

  assign rot_amt      = {field[FIELD_W-1:BYTE_W], 1'b0};
  assign rot_happened = (rot_amt != '0);
  assign base         = {{(WORD_W-BYTE_W){1'b0}}, field[BYTE_W-1:0]};
  assign value        = rotr_word(base, rot_amt);
  assign carry_out    = rot_happened ? value[WORD_W-1] : carry_in;

  always_comb begin
    // a rotation only moves bits, never creates or drops them
    assert_wide_ones_R1: assert ($countones(value) == $countones(field[BYTE_W-1:0]))
      else $error("wide expansion changed the number of set bits");
    if (!rot_happened) begin
      assert_wide_norot_R2: assert (value[WORD_W-1:BYTE_W] == '0 && carry_out == carry_in)
        else $error("unrotated wide constant is not a plain byte with carry-in");
    end
  end

endmodule

// File: rtl/imm_compact_expand.sv
module imm_compact_expand
  import imm_expand_pkg::*;
(
  input  field_t field,
  input  logic   carry_in,
  output word_t  value,
  output logic   carry_out,
  output logic   rot_happened
);

  rep_pat_e   pattern;
  lane_mask_t lanes;
  byte_t      low_byte;
  word_t      rep_value;
  word_t      rot_base;
  word_t      rot_value;

  assign rot_happened = (field[FIELD_W-1:FIELD_W-2] != 2'b00);
  assign pattern      = rep_pat_e'(field[BYTE_W+1:BYTE_W]);
  assign lanes        = lane_mask(pattern);
  assign low_byte     = field[BYTE_W-1:0];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rep_value[g*BYTE_W +: BYTE_W] = lanes[g] ? low_byte : '0;
  end

  assign rot_base  = {{(WORD_W-BYTE_W){1'b0}}, 1'b1, field[BYTE_W-2:0]};
  assign rot_value = rotr_word(rot_base, field[FIELD_W-1:BYTE_W-1]);

  assign value     = rot_happened ? rot_value : rep_value;
  assign carry_out = rot_happened ? value[WORD_W-1] : carry_in;

  always_comb begin
    if (!rot_happened) begin
      // replicated copies: 1, 2, 2 or 4 of the byte
      assert_rep_ones_R5: assert ($countones(value) ==
          $countones(low_byte) * ((pattern == REP_ALL) ? 4 : (pattern == REP_LOW) ? 1 : 2))
        else $error("replicated constant has wrong population");
    end else begin
      assert_rot_ones_R7: assert ($countones(value) == $countones(field[BYTE_W-2:0]) + 1)
        else $error("rotated constant has wrong population");
      assert_rot_high_R8: assert (value[WORD_W-1:BYTE_W] != '0)
        else $error("forced leading one fell into the low byte");
      assert_rot_carry_R7: assert (carry_out == value[WORD_W-1])
        else $error("rotated carry-out does not follow the top bit");
    end
  end

endmodule

// File: rtl/imm_expander.sv
module imm_expander
  import imm_expand_pkg::*;
(
  input  logic [31:0] instr_word,
  input  logic        fmt_compact,
  input  logic        carry_in,
  output logic [31:0] imm_value,
  output logic        carry_out,
  output logic [31:0] imm_plain
);

  field_t field;
  word_t  wide_value;
  word_t  cmp_value;
  logic   wide_carry;
  logic   cmp_carry;
  logic   wide_rot;
  logic   cmp_rot;

  imm_field_gather u_gather (
    .instr_word  (instr_word),
    .fmt_compact (fmt_compact),
    .field       (field)
  );

  imm_wide_expand u_wide (
    .field        (field),
    .carry_in     (carry_in),
    .value        (wide_value),
    .carry_out    (wide_carry),
    .rot_happened (wide_rot)
  );

  imm_compact_expand u_compact (
    .field        (field),
    .carry_in     (carry_in),
    .value        (cmp_value),
    .carry_out    (cmp_carry),
    .rot_happened (cmp_rot)
  );

  assign imm_value = fmt_compact ? cmp_value : wide_value;
  assign carry_out = fmt_compact ? cmp_carry : wide_carry;
  assign imm_plain = {{(WORD_W-FIELD_W){1'b0}}, field};

  always_comb begin
    assert_plain_zext_R9: assert (imm_plain[WORD_W-1:FIELD_W] == '0)
      else $error("plain field is not zero-extended");
    if (!fmt_compact && !wide_rot) begin
      // unrotated wide constant equals the raw field
      assert_wide_plain_R1: assert (imm_value == imm_plain)
        else $error("unrotated wide constant differs from the raw field");
    end
    if (fmt_compact && !cmp_rot) begin
      assert_rep_carry_R6: assert (carry_out == carry_in)
        else $error("replicated constant altered the carry");
    end
  end

endmodule

// File: tb/imm_expander_tb_top.sv
module imm_expander_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr_word = '0;
  logic        fmt_compact = 1'b0;
  logic        carry_in = 1'b0;
  logic [31:0] imm_value;
  logic        carry_out;
  logic [31:0] imm_plain;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  imm_expander dut_i (
    .instr_word  (instr_word),
    .fmt_compact (fmt_compact),
    .carry_in    (carry_in),
    .imm_value   (imm_value),
    .carry_out   (carry_out),
    .imm_plain   (imm_plain)
  );

  typedef struct packed {
    logic [31:0] ins;
    logic        fmt;
    logic        cin;
    logic [31:0] val;
    logic        c;
    logic [31:0] plain;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_00AB, 1'b0, 1'b1, 32'h0000_00AB, 1'b1, 32'h0000_00AB, 8'd2},  // R2 no rotate
    '{32'h0000_01FF, 1'b0, 1'b0, 32'hC000_003F, 1'b1, 32'h0000_01FF, 8'd1},  // R1 rot 2
    '{32'h0000_0F01, 1'b0, 1'b1, 32'h0000_0004, 1'b0, 32'h0000_0F01, 8'd1},  // R1 rot 30
    '{32'hFFFF_F4A5, 1'b0, 1'b0, 32'hA500_0000, 1'b1, 32'h0000_04A5, 8'd2},  // R2 rot 8
    '{32'h0000_0000, 1'b0, 1'b1, 32'h0000_0000, 1'b1, 32'h0000_0000, 8'd2},  // R2 zero
    '{32'h0000_00C3, 1'b1, 1'b0, 32'h0000_00C3, 1'b0, 32'h0000_00C3, 8'd4},  // R4
    '{32'h0000_105A, 1'b1, 1'b1, 32'h005A_005A, 1'b1, 32'h0000_015A, 8'd5},  // R5 halves
    '{32'h0000_2081, 1'b1, 1'b0, 32'h8100_8100, 1'b0, 32'h0000_0281, 8'd5},  // R5 odd lanes
    '{32'h0000_30FF, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b1, 32'h0000_03FF, 8'd6},  // R6 all lanes
    '{32'h0000_3000, 1'b1, 1'b1, 32'h0000_0000, 1'b1, 32'h0000_0300, 8'd10}, // R10 zero byte
    '{32'h0000_4000, 1'b1, 1'b0, 32'h8000_0000, 1'b1, 32'h0000_0400, 8'd7},  // R7 rot 8
    '{32'h0400_70FF, 1'b1, 1'b1, 32'h0000_01FE, 1'b0, 32'h0000_0FFF, 8'd8},  // R8 rot 31
    '{32'h0400_0080, 1'b1, 1'b1, 32'h0040_0000, 1'b0, 32'h0000_0880, 8'd7},  // R7 rot 17
    '{32'hFBFF_8F00, 1'b1, 1'b1, 32'h0000_0000, 1'b1, 32'h0000_0000, 8'd3},  // R3 ignored bits
    '{32'h0400_4035, 1'b1, 1'b1, 32'h0000_B500, 1'b0, 32'h0000_0C35, 8'd3},  // R3 compact gather
    '{32'h0400_4035, 1'b0, 1'b1, 32'h0000_0035, 1'b1, 32'h0000_0035, 8'd9}   // R9 wide plain
  };

  // independent model: rotation by doubled word, replication by concatenation
  function automatic logic [32:0] model(logic [31:0] ins, logic fmt, logic cin);
    logic [11:0] f;
    logic [7:0]  b;
    logic [63:0] dbl;
    logic [31:0] v;
    logic [5:0]  amt;
    logic        c;
    f = fmt ? {ins[26], ins[14:12], ins[7:0]} : ins[11:0];
    b = f[7:0];
    if (!fmt) begin
      amt = {1'b0, f[11:8], 1'b0};
      dbl = {24'h0, b, 24'h0, b} >> amt;
      v = dbl[31:0];
      c = (amt == 0) ? cin : v[31];
    end else if (f[11:10] == 2'b00) begin
      case (f[9:8])
        2'd0:    v = {24'h0, b};
        2'd1:    v = {8'h0, b, 8'h0, b};
        2'd2:    v = {b, 8'h0, b, 8'h0};
        default: v = {b, b, b, b};
      endcase
      c = cin;
    end else begin
      amt = {1'b0, f[11:7]};
      dbl = {24'h0, 1'b1, f[6:0], 24'h0, 1'b1, f[6:0]} >> amt;
      v = dbl[31:0];
      c = v[31];
    end
    return {c, v};
  endfunction

  task automatic apply(input logic [31:0] ins, input logic fmt, input logic cin);
    @(posedge clk);
    #1;
    instr_word  = ins;
    fmt_compact = fmt;
    carry_in    = cin;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (instr=%h fmt=%0b cin=%0b)",
               req, act, exp, instr_word, fmt_compact, carry_in);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    rst_n = 1'b1;

    // table of hand-computed vectors
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].ins, VECS[i].fmt, VECS[i].cin);
      check($sformatf("R%0d value/carry", VECS[i].req), {carry_out, imm_value},
            {VECS[i].c, VECS[i].val});
      check("R9 plain", {1'b0, imm_plain}, {1'b0, VECS[i].plain});
    end

    // R3: compact format ignores bits outside the gathered slices
    apply(32'h0000_0F5A, 1'b1, 1'b0);
    begin
      logic [32:0] ref_v;
      ref_v = {carry_out, imm_value};
      apply(32'hFBFF_8F5A & 32'hFBFF_8F5A | 32'hF800_0F00, 1'b1, 1'b0);
      check("R3 ignored bits", {carry_out, imm_value}, ref_v);
    end

    // full sweep of both encodings
    for (int f = 0; f < 4096; f++) begin
      logic [11:0] fv;
      logic [31:0] ins;
      logic        cin;
      fv  = 12'(f);
      cin = fv[0] ^ fv[5];
      ins = {20'h9C3E7, fv};
      apply(ins, 1'b0, cin);
      check("R1 R2 wide sweep", {carry_out, imm_value}, model(ins, 1'b0, cin));
      check("R9 wide plain sweep", {1'b0, imm_plain}, {21'h0, fv});
      ins = {5'b10110, fv[11], 11'b10100110101, fv[10:8], 4'b1001, fv[7:0]};
      apply(ins, 1'b1, cin);
      check("R4 R5 R6 R7 compact sweep", {carry_out, imm_value}, model(ins, 1'b1, cin));
      check("R9 compact plain sweep", {1'b0, imm_plain}, {21'h0, fv});
      if (fv[11:10] != 2'b00)
        check("R8 high placement", {32'h0, imm_value[31:8] != 24'h0}, 33'h1);
      if (fv[11:10] == 2'b00 && fv[7:0] == 8'h00)
        check("R10 zero byte", {1'b0, imm_value}, 33'h0);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule